// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital sequencer of a 12-bit successive-approximation converter with a single-ended input. A conversion frame starts when the active-low chip select is seen low at a rising clock edge. Two cycles of tracking follow. Then twelve cycles each decide one result bit, most significant first, from a single comparator decision. Two quiet cycles close the frame. The DAC word is driven as two 6-bit halves. The top three bits are not sent in binary: they go out as seven thermometer lines, which keeps the upper DAC steps monotonic.

Each decided bit is sent out at once on a serial data pin. That pin is enabled only while chip select is low. How long chip select stays low selects the operating mode. A short frame puts the analog circuits into power-down. A full frame converts, and it also wakes the analog circuits if they were down. The result of a wake-up frame is marked invalid. With a 16-cycle frame at 8 MHz, one sample takes the 2 µs that a 500 kS/s rate allows.

Top module: `sar_conv_ctrl`

## Requirements
- R1: During and right after reset: `res_word` = 0, `res_ok` = 0, `pwr_dn` = 0, `track` = 0, `dac_therm` = 0, `dac_mid` = 0 and `dac_lo` = 0. The internal trial word is at midscale (0x800).
- R2: A frame begins at the first rising edge that samples `cs_n` low. The frame cycle count is 0 in the cycle after that edge and goes up by one per edge. `track` is 1 in frame cycles 0 and 1 and is 0 at all other times.
- R3: On the edge that ends cycle 1, the trial word is loaded with only bit 11 set. In cycle 2+i the trial bit is b = 11-i. On the edge that ends that cycle, bit b is cleared if `cmp_hi` = 1 and kept at 1 otherwise, and bit b-1 is set. The final word is the largest code whose DAC value does not exceed the input.
- R4: In cycles 2 to 13, `dac_therm` line k (bit k, k = 0..6) is 1 exactly when trial bits [11:9] > k. In all other cycles every line is 0.
- R5: `dac_mid` always carries trial bits [8:6] and `dac_lo` always carries trial bits [5:0].
- R6: Result bit b appears on `sdo` in frame cycle 14-b (cycles 3 to 14, MSB first). In every other frame cycle `sdo` is 0.
- R7: `sdo_oe` equals the inverse of `cs_n`. While `sdo_oe` is 0, `sdo` is 0.
- R8: If a rising edge samples `cs_n` high during a frame whose cycle count is below 10, `pwr_dn` becomes 1. `res_word` and `res_ok` keep their values.
- R9: If a rising edge samples `cs_n` high during a frame whose cycle count is 10 to 15, `pwr_dn`, `res_word` and `res_ok` keep their values.
- R10: A full frame completes on the edge that ends cycle 15 with `cs_n` still low. At that edge `res_word` takes the conversion result, `pwr_dn` becomes 0, and `res_ok` becomes 1, or 0 if `pwr_dn` was 1 when the frame began.
- R11: If `cs_n` stays low after a frame completes, no new frame starts: `track` and the DAC thermometer lines stay 0 until `cs_n` has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low; its length sets the mode |
| cmp_hi | input | 1 | Comparator: 1 when the DAC output is above the held input |
| track | output | 1 | Sampling switch control, 1 while tracking |
| dac_therm | output | 7 | Thermometer lines for trial bits [11:9] |
| dac_mid | output | 3 | Binary trial bits [8:6] (high segment) |
| dac_lo | output | 6 | Binary trial bits [5:0] (low segment) |
| sdo | output | 1 | Serial result bit |
| sdo_oe | output | 1 | Output enable for the serial pin |
| pwr_dn | output | 1 | Power-down enable for the analog circuits |
| res_word | output | 12 | Result of the last full frame |
| res_ok | output | 1 | 1 when `res_word` came from a frame that started in work mode |

## Verification
The hardest situations to reach are the edges of the chip-select length. A release at cycle 9 must power the block down, a release at cycle 10 must not, and a frame that runs past its end must not start again. The bench drives frames of exact lengths from a task, so the release edge lands on each of these cycle counts. It also chains a power-down frame, a wake-up frame and a normal frame, to check the invalid flag and its later recovery. A behavioural comparator rebuilds the DAC value from the thermometer and binary lines, so every conversion closes the loop through the outputs that really drive the DAC.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int SAR_BITS   = 12;
    localparam int SEG_BITS   = 6;
    localparam int THERM_BITS = 3;
    localparam int TRACK_CYC  = 2;
    localparam int FRAME_CYC  = 16;
    localparam int ABORT_LIM  = 10;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_RUN  = 2'd1,
        FS_HOLD = 2'd2
    } frame_state_e;

    typedef struct packed {
        logic start;     // frame begins at this edge
        logic release_pd; // early release, go to power-down
        logic complete;  // full frame ends at this edge
    } frame_evt_t;

endpackage

// File: rtl/sar_frame_timer.sv
module sar_frame_timer
    import sar_pkg::*;
#(
    parameter int FRAME_LEN = FRAME_CYC,
    parameter int ABORT_AT  = ABORT_LIM,
    localparam int CNT_W    = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    output logic             running,
    output logic [CNT_W-1:0] cycle,
    output frame_evt_t       evt
);

    frame_state_e state_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        evt.start      = (state_q == FS_IDLE) && !cs_n;
        evt.release_pd = (state_q == FS_RUN) && cs_n && (cnt_q < CNT_W'(ABORT_AT));
        evt.complete   = (state_q == FS_RUN) && !cs_n && (cnt_q == CNT_W'(FRAME_LEN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                FS_IDLE: begin
                    if (!cs_n) begin
                        state_q <= FS_RUN;
                        cnt_q   <= '0;
                    end
                end
                FS_RUN: begin
                    if (cs_n) begin
                        state_q <= FS_IDLE;
                    end else if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
                        state_q <= FS_HOLD;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                FS_HOLD: begin
                    if (cs_n) state_q <= FS_IDLE;
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    assign running = (state_q == FS_RUN);
    assign cycle   = cnt_q;

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg
    import sar_pkg::*;
#(
    parameter int NBITS   = SAR_BITS,
    parameter int TRK     = TRACK_CYC,
    parameter int CNT_W   = 4,
    localparam int IDX_W  = $clog2(NBITS),
    localparam int LAST   = TRK + NBITS - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             running,
    input  logic [CNT_W-1:0] cycle,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] word,
    output logic             deciding,
    output logic             ser_bit
);

    localparam logic [NBITS-1:0] MIDSCALE = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] word_q;
    logic             ser_q;
    logic             load_mid;
    logic [IDX_W-1:0] trial_idx;

    always_comb begin
        deciding  = running && (cycle >= CNT_W'(TRK)) && (cycle <= CNT_W'(LAST));
        load_mid  = running && !cs_n && (cycle == CNT_W'(TRK - 1));
        trial_idx = IDX_W'(LAST) - IDX_W'(cycle);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= MIDSCALE;
            ser_q  <= 1'b0;
        end else begin
            ser_q <= 1'b0;
            if (load_mid) begin
                word_q <= MIDSCALE;
            end else if (deciding && !cs_n) begin
                word_q[trial_idx] <= ~cmp_hi;
                if (trial_idx != '0) word_q[trial_idx - 1'b1] <= 1'b1;
                ser_q <= ~cmp_hi;
            end
        end
    end

    assign word    = word_q;
    assign ser_bit = ser_q;

endmodule

// File: rtl/sar_therm_enc.sv
module sar_therm_enc #(
    parameter int IN_W   = 3,
    localparam int LINES = (1 << IN_W) - 1
) (
    input  logic             en,
    input  logic [IN_W-1:0]  val,
    output logic [LINES-1:0] lines
);

    for (genvar k = 0; k < LINES; k++) begin : g_line
        assign lines[k] = en && (val > IN_W'(k));
    end

endmodule

// File: rtl/sar_mode_ctl.sv
module sar_mode_ctl
    import sar_pkg::*;
#(
    parameter int NBITS = SAR_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_evt_t       evt,
    input  logic [NBITS-1:0] word,
    output logic             pwr_dn,
    output logic [NBITS-1:0] res_word,
    output logic             res_ok
);

    logic pd_q;
    logic wake_q;
    logic [NBITS-1:0] res_q;
    logic ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q   <= 1'b0;
            wake_q <= 1'b0;
            res_q  <= '0;
            ok_q   <= 1'b0;
        end else begin
            if (evt.start) wake_q <= pd_q;
            if (evt.release_pd) pd_q <= 1'b1;
            if (evt.complete) begin
                res_q <= word;
                ok_q  <= ~wake_q;
                pd_q  <= 1'b0;
            end
        end
    end

    assign pwr_dn   = pd_q;
    assign res_word = res_q;
    assign res_ok   = ok_q;

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int NBITS     = SAR_BITS,
    parameter int SEG_W     = SEG_BITS,
    parameter int THERM_W   = THERM_BITS,
    parameter int TRACK_LEN = TRACK_CYC,
    parameter int FRAME_LEN = FRAME_CYC,
    parameter int ABORT_AT  = ABORT_LIM,
    localparam int LINES    = (1 << THERM_W) - 1,
    localparam int MID_W    = NBITS - SEG_W - THERM_W,
    localparam int CNT_W    = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              cmp_hi,
    output logic              track,
    output logic [LINES-1:0]  dac_therm,
    output logic [MID_W-1:0]  dac_mid,
    output logic [SEG_W-1:0]  dac_lo,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              pwr_dn,
    output logic [NBITS-1:0]  res_word,
    output logic              res_ok
);

    logic             running;
    logic [CNT_W-1:0] cycle;
    frame_evt_t       evt;
    logic [NBITS-1:0] word;
    logic             deciding;
    logic             ser_bit;

    sar_frame_timer #(
        .FRAME_LEN (FRAME_LEN),
        .ABORT_AT  (ABORT_AT)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .running (running),
        .cycle   (cycle),
        .evt     (evt)
    );

    sar_approx_reg #(
        .NBITS (NBITS),
        .TRK   (TRACK_LEN),
        .CNT_W (CNT_W)
    ) u_sar (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .running  (running),
        .cycle    (cycle),
        .cmp_hi   (cmp_hi),
        .word     (word),
        .deciding (deciding),
        .ser_bit  (ser_bit)
    );

    sar_therm_enc #(
        .IN_W (THERM_W)
    ) u_therm (
        .en    (deciding),
        .val   (word[NBITS-1 -: THERM_W]),
        .lines (dac_therm)
    );

    sar_mode_ctl #(
        .NBITS (NBITS)
    ) u_mode (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .word     (word),
        .pwr_dn   (pwr_dn),
        .res_word (res_word),
        .res_ok   (res_ok)
    );

    assign track   = running && (cycle < CNT_W'(TRACK_LEN));
    assign dac_mid = word[SEG_W +: MID_W];
    assign dac_lo  = word[SEG_W-1:0];
    assign sdo_oe  = ~cs_n;
    assign sdo     = sdo_oe & ser_bit;

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int LINES = 7,
    parameter int NBITS = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             track,
    input logic [LINES-1:0] dac_therm,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             pwr_dn,
    input logic [NBITS-1:0] res_word,
    input logic             res_ok
);

    p_therm_shape_r4: assert property (@(posedge clk) disable iff (rst)
        dac_therm == LINES'((1 << $countones(dac_therm)) - 1));

    p_therm_off_track_r4: assert property (@(posedge clk) disable iff (rst)
        track |-> (dac_therm == '0));

    p_track_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(track) |-> $past(!cs_n));

    p_pin_off_r7: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sdo_oe && !sdo));

    p_pd_entry_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_dn) |-> $past(cs_n));

    p_pd_exit_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_dn) |-> $past(!cs_n));

    p_result_update_r10: assert property (@(posedge clk) disable iff (rst)
        (res_word != $past(res_word) || res_ok != $past(res_ok)) |-> $past(!cs_n));

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
    .LINES (LINES),
    .NBITS (NBITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .track     (track),
    .dac_therm (dac_therm),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .pwr_dn    (pwr_dn),
    .res_word  (res_word),
    .res_ok    (res_ok)
);

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        cmp_hi;
    logic        track;
    logic [6:0]  dac_therm;
    logic [2:0]  dac_mid;
    logic [5:0]  dac_lo;
    logic        sdo;
    logic        sdo_oe;
    logic        pwr_dn;
    logic [11:0] res_word;
    logic        res_ok;

    int unsigned vin = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [11:0] word;
        logic        ok;
    } exp_t;
    exp_t exp_q[$];

    logic [11:0] m_word = '0;
    logic        m_ok = 1'b0;
    logic        m_pd = 1'b0;

    always #5 clk = ~clk;

    // behavioural comparator on the DAC lines
    int unsigned dac_val;
    assign dac_val = $countones(dac_therm) * 512 + int'(dac_mid) * 64 + int'(dac_lo);
    assign cmp_hi  = (dac_val > vin);

    sar_conv_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .cmp_hi    (cmp_hi),
        .track     (track),
        .dac_therm (dac_therm),
        .dac_mid   (dac_mid),
        .dac_lo    (dac_lo),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .pwr_dn    (pwr_dn),
        .res_word  (res_word),
        .res_ok    (res_ok)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one frame with cs_n low for len edges
    task automatic frame(input int unsigned v, input int len);
        bit full;
        full = (len >= 17);
        vin = v;
        if (full) exp_q.push_back('{word: 12'(v), ok: !m_pd});
        cs_n = 1'b0;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (i <= 16) chk(track == (i <= 2), "R2 track", track, (i <= 2));
            if (i == 3) chk(dac_therm == 7'b0001111, "R4 MSB trial lines", dac_therm, 7'h0f);
            if (i == 14 && full)
                chk(dac_therm == 7'((1 << v[11:9]) - 1), "R4 last trial lines", dac_therm, (1 << v[11:9]) - 1);
            if (i == 15 && full) begin
                chk(dac_therm == 7'd0, "R4 lines off after decisions", dac_therm, 0);
                chk({dac_mid, dac_lo} == v[8:0], "R5 segments", {dac_mid, dac_lo}, v[8:0]);
            end
            if (i >= 18) begin
                chk(track == 1'b0 && dac_therm == 7'd0, "R11 no restart", {track, dac_therm}, 0);
                chk(sdo_oe == 1'b1, "R7 enable while low", sdo_oe, 1);
            end
        end
        cs_n = 1'b1;
        @(negedge clk);
        chk(sdo_oe == 1'b0 && sdo == 1'b0, "R7 pin off", {sdo_oe, sdo}, 0);
        if (!full) begin
            if (len <= 10) m_pd = 1'b1;
            chk(pwr_dn == m_pd, (len <= 10) ? "R8 power-down" : "R9 no mode change", pwr_dn, m_pd);
            chk(res_word == m_word && res_ok == m_ok, (len <= 10) ? "R8 result kept" : "R9 result kept",
                {res_ok, res_word}, {m_ok, m_word});
        end
        repeat (2) @(negedge clk);
    endtask

    // monitor: serial bits and completion results
    initial begin
        int n = 0;
        logic [11:0] ser = '0;
        forever begin
            @(posedge clk);
            if (rst || cs_n) n = 0; else n++;
            @(negedge clk);
            #1;
            if (n >= 2 && n <= 16 && !(n >= 4 && n <= 15))
                chk(sdo == 1'b0, "R6 idle serial", sdo, 0);
            if (n >= 4 && n <= 15) ser = {ser[10:0], sdo};
            if (n == 17) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    chk(0, "R10 unexpected frame", 0, 1);
                end else begin
                    e = exp_q.pop_front();
                    chk(ser == e.word, "R6 serial word", ser, e.word);
                    chk(res_word == e.word, "R3 result", res_word, e.word);
                    chk(res_ok == e.ok, "R10 valid flag", res_ok, e.ok);
                    chk(pwr_dn == 1'b0, "R10 work mode", pwr_dn, 0);
                    m_word = e.word;
                    m_ok   = e.ok;
                    m_pd   = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(res_word == 12'd0 && res_ok == 1'b0, "R1 result cleared", {res_ok, res_word}, 0);
        chk(pwr_dn == 1'b0 && track == 1'b0, "R1 mode", {pwr_dn, track}, 0);
        chk(dac_therm == 7'd0 && dac_mid == 3'd0 && dac_lo == 6'd0, "R1 DAC midscale",
            {dac_therm, dac_mid, dac_lo}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(dac_therm == 7'd0 && {dac_mid, dac_lo} == 9'd0, "R1 after release",
            {dac_therm, dac_mid, dac_lo}, 0);
        frame(12'd1234, 17);
        frame(12'd0, 17);
        frame(12'd4095, 17);
        frame(12'd2048, 17);
        frame(12'd2047, 17);
        frame(12'hAAA, 22);
        frame(12'd300, 11);
        frame(12'd300, 10);
        frame(12'd555, 4);
        frame(12'd3000, 17);
        frame(12'h5A5, 17);
        frame(12'd77, 1);
        frame(12'h123, 17);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all frames done", exp_q.size(), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                chk(0, "watchdog", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule